// File: doc/BRIEF.md
# Punctured Convolutional FEC Encoder

This block is the bit-serial channel coder of an OFDM transmit chain. Each randomized data bit it accepts is fed through a constraint-length-7, rate-1/2 convolutional code. The two coded bits of each step are thinned by a puncturing pattern to an overall rate of 1/2, 2/3 or 3/4. The surviving bits leave one per cycle on a valid/ready stream.

A block of data is framed by a start flag on its first bit and an end flag on its last bit. The start flag clears the coder memory, restarts the puncturing phase and samples the rate selection. The end flag makes the coder run six further steps with zero input. Those steps bring its memory back to the all-zero state, and their coded bits are punctured and sent like any others. The final coded bit of a block carries an end marker.

The output side can stall at any time. While a coded bit waits, no new input bit or tail step is taken.

Top module: `conv_punct_enc`

## Requirements
- R1: For every step with input bit u(t), the coded pair is X = u(t)^u(t-2)^u(t-3)^u(t-5)^u(t-6) and Y = u(t)^u(t-1)^u(t-2)^u(t-3)^u(t-6). Bits before the first bit of the block count as zero.
- R2: With `rate_sel` = 0 (rate 1/2), every step emits X then Y, in that order.
- R3: With `rate_sel` = 1 (rate 2/3), steps cycle with period 2. Phase 0 emits X then Y, and phase 1 emits Y only.
- R4: With `rate_sel` = 2 (rate 3/4), steps cycle with period 3. Phase 0 emits X then Y, phase 1 emits Y only, and phase 2 emits X only.
- R5: `rate_sel` is sampled only on the accepted bit flagged `in_first`. Values on later bits of the block have no effect, and code 3 behaves as rate 1/2.
- R6: The puncturing phase restarts at phase 0 on every accepted `in_first` bit, whatever phase the previous block ended in.
- R7: After the bit flagged `in_last`, six zero-input tail steps are encoded and punctured with the phase continuing. `out_last` is high exactly on the final coded bit of the block, and nothing follows it until new input arrives.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold. `in_ready` is low whenever a coded bit is pending or tail steps remain.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder takes the offered bit this cycle |
| in_bit | input | 1 | Randomized data bit |
| in_first | input | 1 | Offered bit starts a block |
| in_last | input | 1 | Offered bit ends a block |
| rate_sel | input | 2 | 0: rate 1/2, 1: rate 2/3, 2: rate 3/4, 3: rate 1/2 |
| out_valid | output | 1 | Coded bit is offered |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_bit | output | 1 | Coded bit |
| out_last | output | 1 | Coded bit is the last of the block |

## Verification
The bench checks the impulse response of a single-bit block against a fixed coded sequence. A design with a wrong tap or with swapped generators would disagree there bit for bit. It runs back-to-back short rate-3/4 blocks whose tails end mid-pattern, which exposes a design that fails to restart the puncturing phase. It toggles `rate_sel` after the first bit, which catches a design that decodes the rate live. Under periodic output stalls it checks that pending bits hold and that no input slips in during the tail. A design that dropped or duplicated a bit, or misplaced the end marker, would show a wrong bit count or `out_last` on the wrong bit.

// File: rtl/fec_pkg.sv
package fec_pkg;

  localparam int CONSTR_LEN = 7;
  localparam int MEM_LEN    = CONSTR_LEN - 1;
  localparam logic [CONSTR_LEN-1:0] GEN_X = 7'o133;
  localparam logic [CONSTR_LEN-1:0] GEN_Y = 7'o171;

  typedef enum logic [1:0] {
    RATE_1_2 = 2'd0,
    RATE_2_3 = 2'd1,
    RATE_3_4 = 2'd2
  } rate_e;

  // Parity of the register window under a generator mask; MSB is the newest bit.
  function automatic logic gen_parity(input logic [CONSTR_LEN-1:0] win,
                                      input logic [CONSTR_LEN-1:0] gen);
    return ^(win & gen);
  endfunction

  function automatic rate_e decode_rate(input logic [1:0] sel);
    case (sel)
      2'd1:    return RATE_2_3;
      2'd2:    return RATE_3_4;
      default: return RATE_1_2;
    endcase
  endfunction

  function automatic logic [1:0] pattern_len(input rate_e r);
    case (r)
      RATE_2_3: return 2'd2;
      RATE_3_4: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

  // Returns {keep_x, keep_y} for a phase of the puncturing pattern.
  function automatic logic [1:0] keep_mask(input rate_e r, input logic [1:0] ph);
    case (r)
      RATE_2_3: return (ph == 2'd0) ? 2'b11 : 2'b01;
      RATE_3_4: begin
        case (ph)
          2'd0:    return 2'b11;
          2'd1:    return 2'b01;
          default: return 2'b10;
        endcase
      end
      default:  return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/conv_core.sv
module conv_core
  import fec_pkg::*;
#(
  parameter int K = CONSTR_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic         din,
  output logic         cx,
  output logic         cy,
  output logic [K-2:0] state
);

  logic [K-2:0] mem_q;
  logic [K-2:0] mem_eff;
  logic [K-1:0] window;

  assign mem_eff = clr ? '0 : mem_q;
  assign window  = {din, mem_eff};
  assign cx      = gen_parity(window, GEN_X);
  assign cy      = gen_parity(window, GEN_Y);
  assign state   = mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (step) begin
      mem_q <= window[K-1:1];
    end
  end

endmodule

// File: rtl/punct_sel.sv
module punct_sel
  import fec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  restart,
  input  rate_e rate,
  output logic  keep_x,
  output logic  keep_y
);

  logic [1:0] ph_q;
  logic [1:0] ph_eff;
  logic [1:0] ph_inc;

  assign ph_eff           = restart ? 2'd0 : ph_q;
  assign ph_inc           = ph_eff + 2'd1;
  assign {keep_x, keep_y} = keep_mask(rate, ph_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
    end else if (step) begin
      ph_q <= (ph_inc >= pattern_len(rate)) ? 2'd0 : ph_inc;
    end
  end

endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
  import fec_pkg::*;
#(
  parameter int TAIL_LEN = MEM_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_first,
  input  logic       in_last,
  input  logic [1:0] rate_sel,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       out_last
);

  localparam int TW = $clog2(TAIL_LEN + 1);

  logic          x_pend, y_pend, px, py, pair_last, tailing;
  logic [TW-1:0] tail_cnt;
  rate_e         rate_q, rate_eff;
  logic          step_in, step_tail, step, blk_start, step_bit, tail_done;
  logic          cx, cy, keep_x, keep_y;
  logic [MEM_LEN-1:0] enc_state;

  assign out_valid = x_pend | y_pend;
  assign out_bit   = x_pend ? px : py;
  assign out_last  = pair_last & out_valid & ~(x_pend & y_pend);
  assign in_ready  = ~out_valid & ~tailing;

  assign step_in   = in_valid & in_ready;
  assign step_tail = tailing & ~out_valid;
  assign step      = step_in | step_tail;
  assign blk_start = step_in & in_first;
  assign step_bit  = step_in & in_bit;
  assign tail_done = step_tail & (tail_cnt == TW'(1));
  assign rate_eff  = blk_start ? decode_rate(rate_sel) : rate_q;

  conv_core #(.K(CONSTR_LEN)) core_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .clr   (blk_start),
    .din   (step_bit),
    .cx    (cx),
    .cy    (cy),
    .state (enc_state)
  );

  punct_sel punct_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (blk_start),
    .rate    (rate_eff),
    .keep_x  (keep_x),
    .keep_y  (keep_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_pend    <= 1'b0;
      y_pend    <= 1'b0;
      px        <= 1'b0;
      py        <= 1'b0;
      pair_last <= 1'b0;
      tailing   <= 1'b0;
      tail_cnt  <= '0;
      rate_q    <= RATE_1_2;
    end else begin
      if (step) begin
        px        <= cx;
        py        <= cy;
        x_pend    <= keep_x;
        y_pend    <= keep_y;
        pair_last <= tail_done;
      end else if (out_valid && out_ready) begin
        if (x_pend) x_pend <= 1'b0;
        else        y_pend <= 1'b0;
      end
      if (blk_start) rate_q <= decode_rate(rate_sel);
      if (step_in && in_last) begin
        tailing  <= 1'b1;
        tail_cnt <= TW'(TAIL_LEN);
      end else if (step_tail) begin
        tail_cnt <= tail_cnt - TW'(1);
        if (tail_done) tailing <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/conv_punct_enc_chk.sv
module conv_punct_enc_chk
  import fec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_bit,
  input logic               out_last,
  input logic               step,
  input logic               keep_x,
  input logic               keep_y,
  input logic               tail_done,
  input logic [MEM_LEN-1:0] enc_state
);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));

  a_r7_flush_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tail_done |=> enc_state == '0);

  a_r7_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r7_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r3_step_keeps_a_bit: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (keep_x || keep_y));

endmodule

bind conv_punct_enc conv_punct_enc_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_last  (out_last),
  .step      (step),
  .keep_x    (keep_x),
  .keep_y    (keep_y),
  .tail_done (tail_done),
  .enc_state (enc_state)
);

// File: tb/conv_punct_enc_tb_top.sv
module conv_punct_enc_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_bit = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_bit, out_last;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  conv_punct_enc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_first(in_first), .in_last(in_last), .rate_sel(rate_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last)
  );

  typedef struct packed { int len; int rate; int seed; int stall; int mid; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1,  0, 0,  0, 0},
    '{16, 0, 5,  0, 0},
    '{12, 1, 7,  0, 0},
    '{12, 2, 11, 0, 0},
    '{4,  2, 3,  0, 0},
    '{20, 1, 13, 3, 0},
    '{18, 2, 9,  0, 1},
    '{10, 3, 6,  2, 0}
  };

  bit inp [64];
  bit exp_bits [256];
  bit cap_bits [256];
  int exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit pick(input int len, input int seed, input int i);
    if (i >= len) return 1'b0;
    if (seed == 0) return (i == 0);
    return 1'(((i * seed + 3) >> 2) ^ i ^ (seed >> 1));
  endfunction

  function automatic bit dly(input int t, input int d);
    return (t - d >= 0) ? inp[t-d] : 1'b0;
  endfunction

  // Independent model: tap delays of both generators and the puncturing tables.
  task automatic build_expect(input int len, input int rate, input int seed);
    int r;
    r = (rate == 3) ? 0 : rate;
    exp_n = 0;
    for (int t = 0; t < len + 6; t++) inp[t] = pick(len, seed, t);
    for (int t = 0; t < len + 6; t++) begin
      bit x, y, kx, ky;
      int ph;
      x = dly(t,0) ^ dly(t,2) ^ dly(t,3) ^ dly(t,5) ^ dly(t,6);
      y = dly(t,0) ^ dly(t,1) ^ dly(t,2) ^ dly(t,3) ^ dly(t,6);
      ph = t % (r + 1);
      kx = (r == 0) || (r == 1 && ph == 0) || (r == 2 && ph != 1);
      ky = !(r == 2 && ph == 2);
      if (kx) begin exp_bits[exp_n] = x; exp_n++; end
      if (ky) begin exp_bits[exp_n] = y; exp_n++; end
    end
  endtask

  task automatic run_block(input int len, input int rate, input int seed,
                           input int stall, input int mid, input string tag);
    int idx = 0, got = 0, cyc = 0;
    int bad_bits = 0, bad_last = 0, bad_hs = 0, extra = 0;
    bit hold_pending = 0, hold_bit = 0;
    build_expect(len, rate, seed);
    while ((idx < len || got < exp_n) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (hold_pending && (!out_valid || out_bit != hold_bit)) bad_hs++;
      if (in_ready && out_valid) bad_hs++;
      if (idx == len && got < exp_n && in_ready) bad_hs++;
      out_ready = (stall == 0) || (cyc % stall != 0);
      in_valid  = (idx < len);
      in_bit    = pick(len, seed, idx);
      in_first  = (idx == 0);
      in_last   = (idx == len - 1);
      rate_sel  = (idx == 0 || mid == 0) ? 2'(rate) : 2'((rate + 1) % 3);
      if (in_valid && in_ready) idx++;
      hold_pending = out_valid && !out_ready;
      hold_bit     = out_bit;
      if (out_valid && out_ready) begin
        if (got < exp_n) begin
          cap_bits[got] = out_bit;
          if (out_bit != exp_bits[got]) bad_bits++;
          if (out_last != (got == exp_n - 1)) bad_last++;
        end else extra++;
        got++;
      end
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    check(bad_bits == 0, tag, "coded bit mismatches", bad_bits, 0);
    check(got == exp_n && extra == 0, "R7", "coded bit count", got + extra, exp_n);
    check(bad_last == 0, "R7", "out_last misplaced", bad_last, 0);
    check(bad_hs == 0, "R8", "handshake violations", bad_hs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [13:0] IMPULSE = 14'b11011111001011;

  initial begin
    // R9: state while held in reset and just after release
    repeat (3) @(negedge clk);
    check(!out_valid, "R9", "out_valid in reset", int'(out_valid), 0);
    check(in_ready, "R9", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9", "idle after reset",
          int'({out_valid, in_ready}), 1);

    for (int v = 0; v < 8; v++) begin
      string tag;
      if (VECS[v].mid != 0 || VECS[v].rate == 3) tag = "R5";
      else if (v == 4) tag = "R6";
      else if (VECS[v].rate == 0) tag = "R2";
      else if (VECS[v].rate == 1) tag = "R3";
      else tag = "R4";
      run_block(VECS[v].len, VECS[v].rate, VECS[v].seed, VECS[v].stall, VECS[v].mid, tag);
      if (v == 0) begin
        // R1: impulse response, X then Y per step, fixed vector
        int mism = 0;
        for (int k = 0; k < 14; k++) if (cap_bits[k] != IMPULSE[13-k]) mism++;
        check(mism == 0, "R1", "impulse response mismatches", mism, 0);
      end
    end

    // R9: reset in the middle of a block returns the ports to idle
    in_valid = 1'b1; in_bit = 1'b1; in_first = 1'b1; in_last = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid, "R8", "pending bit held under stall", int'(out_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R9", "idle after mid-block reset",
          int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule